// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block holds the loop-control state of a counted, software-pipelined loop: a loop counter, an epilog (drain) counter, a file of 64 one-bit predicates, and a rotating-register base. Software loads the two counters and the initial predicate mask. Each loop-closing branch it receives then moves the loop through one of three stages:

- **Prolog and kernel:** new iterations are still starting.
- **Drain:** the in-flight iterations finish.
- **Exit:** the branch falls through.

Every stage of the pipelined loop body is guarded by one of the rotating predicates. A fresh iteration enters at p16, and its set bit moves one predicate up on each taken branch. Stage k therefore runs only after the iteration has reached that stage. On each taken branch the rename base drops by one, modulo the size of the rotating region. A value written to logical r32 in one iteration is therefore read as r33 in the next. A combinational mapper turns a logical general-register index into the physical index using the current base.

The branch result (valid pulse and taken flag) and the updated state are visible one cycle after the branch request. Instruction fetch, the datapath and memory are outside this block.

Top module: `modloop_ctl`

## Requirements
- R1: After reset the loop count and epilog count are 0, the predicate vector has only bit 0 set, the rename base is 0 and `resp_vld` is 0.
- R2: `lc_wr` loads `lc_din` and `ec_wr` loads `ec_din`. `pr_wr` loads predicate bits 63..1 from `pr_din`. Bit 0 of `pr_din` is ignored, and predicate 0 always reads 1.
- R3: An accepted branch with loop count > 0 is taken. It decrements the loop count, keeps the epilog count, and sets the new predicate 16 to 1.
- R4: An accepted branch with loop count = 0 and epilog count > 1 is taken. It decrements the epilog count and sets the new predicate 16 to 0.
- R5: An accepted branch with loop count = 0 and epilog count ≤ 1 falls through. It decrements the epilog count if it is non-zero and leaves the predicates and the rename base unchanged.
- R6: On a taken branch, predicate i+1 takes the old value of predicate i for i = 16..62. Predicates 0..15 keep their values.
- R7: On a taken branch the rename base decrements modulo 96, so 0 becomes 95.
- R8: `map_phys` equals `map_log` when `map_log` < 32. Otherwise it equals 32 + ((`map_log` − 32 + base) mod 96).
- R9: `loop_br` is ignored in any cycle in which `lc_wr`, `ec_wr` or `pr_wr` is high. No response is produced, and only the load changes state.
- R10: Each accepted branch produces exactly one `resp_vld` pulse, one cycle after the request. `resp_taken` is high in that pulse exactly when the branch is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lc_wr | input | 1 | Load strobe for the loop count |
| lc_din | input | 16 | Loop count load value |
| ec_wr | input | 1 | Load strobe for the epilog count |
| ec_din | input | 6 | Epilog count load value |
| pr_wr | input | 1 | Load strobe for the predicate mask |
| pr_din | input | 64 | Predicate mask (bit 0 ignored) |
| loop_br | input | 1 | Loop-closing branch request |
| map_log | input | 7 | Logical general-register index to translate |
| resp_vld | output | 1 | Branch result valid, one cycle after the request |
| resp_taken | output | 1 | Branch taken (1) or fall-through (0) |
| lc_cur | output | 16 | Current loop count |
| ec_cur | output | 6 | Current epilog count |
| pr_vec | output | 64 | Current predicate vector |
| rrb_cur | output | 7 | Current rotating-register base |
| map_phys | output | 7 | Physical register index for `map_log` |

## Verification
The bound checker tests the following on every cycle:
- Predicate 0 stays set.
- Each response follows exactly one accepted request.
- Taken responses shift the rotating predicates up and pull the base down with wrap.
- Fall-through responses leave the predicates and the base untouched.

Only the bench scenarios can show the whole prolog/kernel/drain/exit sequence, with its exact counter values and stage pattern in the predicates. The same applies to the mapper's wrap arithmetic and to the carry of r32 into r33 across a branch. They also show that a branch colliding with a load leaves no trace.

// File: rtl/modloop_pkg.sv
`timescale 1ns/1ps
package modloop_pkg;
  // Stage chosen by a loop-closing branch
  typedef enum logic [1:0] {
    BK_KERNEL = 2'd0,  // new iteration starts
    BK_DRAIN  = 2'd1,  // in-flight iterations drain
    BK_EXIT   = 2'd2   // fall through
  } br_kind_e;
endpackage

// File: rtl/modloop_cnt.sv
`timescale 1ns/1ps
module modloop_cnt
  import modloop_pkg::*;
#(
  parameter int unsigned LC_W = 16,
  parameter int unsigned EC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lc_wr,
  input  logic [LC_W-1:0] lc_din,
  input  logic            ec_wr,
  input  logic [EC_W-1:0] ec_din,
  input  logic            br_acc,
  output br_kind_e        kind,
  output logic [LC_W-1:0] lc_q,
  output logic [EC_W-1:0] ec_q
);
  logic [LC_W-1:0] lc_d;
  logic [EC_W-1:0] ec_d;
  logic            lc_en, ec_en;

  always_comb begin
    if (lc_q != '0)                    kind = BK_KERNEL;
    else if (ec_q > EC_W'(1))          kind = BK_DRAIN;
    else                               kind = BK_EXIT;
  end

  always_comb begin
    lc_d  = lc_q;
    ec_d  = ec_q;
    lc_en = 1'b0;
    ec_en = 1'b0;
    if (lc_wr) begin
      lc_d  = lc_din;
      lc_en = 1'b1;
    end
    if (ec_wr) begin
      ec_d  = ec_din;
      ec_en = 1'b1;
    end
    if (br_acc) begin
      unique case (kind)
        BK_KERNEL: begin
          lc_d  = lc_q - LC_W'(1);
          lc_en = 1'b1;
        end
        BK_DRAIN: begin
          ec_d  = ec_q - EC_W'(1);
          ec_en = 1'b1;
        end
        default: begin
          if (ec_q != '0) begin
            ec_d  = ec_q - EC_W'(1);
            ec_en = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
      ec_q <= '0;
    end else begin
      if (lc_en) lc_q <= lc_d;
      if (ec_en) ec_q <= ec_d;
    end
  end
endmodule

// File: rtl/modloop_predrot.sv
`timescale 1ns/1ps
module modloop_predrot #(
  parameter int unsigned PR_N   = 64,
  parameter int unsigned PR_ROT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pr_wr,
  input  logic [PR_N-1:0] pr_din,
  input  logic            rot_en,
  input  logic            fill,
  output logic [PR_N-1:0] pr_vec
);
  logic [PR_N-1:1] rp_q, rp_d;
  logic            rp_en;

  // Predicate 0 is a constant one; only bits PR_N-1..1 are stored.
  assign pr_vec = {rp_q, 1'b1};

  always_comb begin
    rp_d  = rp_q;
    rp_en = 1'b0;
    if (pr_wr) begin
      rp_d  = pr_din[PR_N-1:1];
      rp_en = 1'b1;
    end else if (rot_en) begin
      // The top predicate would wrap into PR_ROT, but the fill bit replaces it.
      rp_d[PR_N-1:PR_ROT+1] = rp_q[PR_N-2:PR_ROT];
      rp_d[PR_ROT]          = fill;
      rp_en                 = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rp_q <= '0;
    else if (rp_en) rp_q <= rp_d;
  end
endmodule

// File: rtl/modloop_rename.sv
`timescale 1ns/1ps
module modloop_rename #(
  parameter int unsigned GR_N     = 128,
  parameter int unsigned ROT_BASE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rot_en,
  input  logic [$clog2(GR_N)-1:0] map_log,
  output logic [$clog2(GR_N)-1:0] map_phys,
  output logic [$clog2(GR_N)-1:0] rrb_q
);
  localparam int unsigned GR_W  = $clog2(GR_N);
  localparam int unsigned ROT_N = GR_N - ROT_BASE;
  localparam int unsigned SW    = GR_W + 1;

  logic [GR_W-1:0] rrb_d;
  logic [SW-1:0]   rel, sum;

  always_comb begin
    if (rrb_q == '0) rrb_d = GR_W'(ROT_N - 1);
    else             rrb_d = rrb_q - GR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rrb_q <= '0;
    else if (rot_en) rrb_q <= rrb_d;
  end

  always_comb begin
    rel = SW'(map_log) - SW'(ROT_BASE);
    sum = rel + SW'(rrb_q);
    if (sum >= SW'(ROT_N)) sum = sum - SW'(ROT_N);
    if (map_log < GR_W'(ROT_BASE)) map_phys = map_log;
    else                           map_phys = GR_W'(SW'(ROT_BASE) + sum);
  end
endmodule

// File: rtl/modloop_ctl.sv
`timescale 1ns/1ps
module modloop_ctl
  import modloop_pkg::*;
#(
  parameter int unsigned LC_W     = 16,
  parameter int unsigned EC_W     = 6,
  parameter int unsigned PR_N     = 64,
  parameter int unsigned PR_ROT   = 16,
  parameter int unsigned GR_N     = 128,
  parameter int unsigned ROT_BASE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lc_wr,
  input  logic [LC_W-1:0]         lc_din,
  input  logic                    ec_wr,
  input  logic [EC_W-1:0]         ec_din,
  input  logic                    pr_wr,
  input  logic [PR_N-1:0]         pr_din,
  input  logic                    loop_br,
  input  logic [$clog2(GR_N)-1:0] map_log,
  output logic                    resp_vld,
  output logic                    resp_taken,
  output logic [LC_W-1:0]         lc_cur,
  output logic [EC_W-1:0]         ec_cur,
  output logic [PR_N-1:0]         pr_vec,
  output logic [$clog2(GR_N)-1:0] rrb_cur,
  output logic [$clog2(GR_N)-1:0] map_phys
);
  logic [1:0] rst_sync;
  logic       rst_i;
  logic       br_acc, taken, fill;
  br_kind_e   kind;
  logic       vld_d, tkn_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign br_acc = loop_br & ~(lc_wr | ec_wr | pr_wr);
  assign taken  = (kind != BK_EXIT);
  assign fill   = (kind == BK_KERNEL);

  modloop_cnt #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .lc_wr(lc_wr), .lc_din(lc_din),
    .ec_wr(ec_wr), .ec_din(ec_din), .br_acc(br_acc), .kind(kind),
    .lc_q(lc_cur), .ec_q(ec_cur)
  );

  modloop_predrot #(.PR_N(PR_N), .PR_ROT(PR_ROT)) u_pred (
    .clk(clk), .rst_n(rst_i), .pr_wr(pr_wr), .pr_din(pr_din),
    .rot_en(br_acc & taken), .fill(fill), .pr_vec(pr_vec)
  );

  modloop_rename #(.GR_N(GR_N), .ROT_BASE(ROT_BASE)) u_ren (
    .clk(clk), .rst_n(rst_i), .rot_en(br_acc & taken),
    .map_log(map_log), .map_phys(map_phys), .rrb_q(rrb_cur)
  );

  always_comb begin
    vld_d = br_acc;
    tkn_d = br_acc & taken;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      resp_vld   <= 1'b0;
      resp_taken <= 1'b0;
    end else begin
      resp_vld   <= vld_d;
      resp_taken <= tkn_d;
    end
  end
endmodule

// File: rtl/modloop_ctl_chk.sv
`timescale 1ns/1ps
module modloop_ctl_chk #(
  parameter int unsigned LC_W     = 16,
  parameter int unsigned EC_W     = 6,
  parameter int unsigned PR_N     = 64,
  parameter int unsigned PR_ROT   = 16,
  parameter int unsigned GR_N     = 128,
  parameter int unsigned ROT_BASE = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lc_wr,
  input logic                    ec_wr,
  input logic                    pr_wr,
  input logic                    loop_br,
  input logic                    resp_vld,
  input logic                    resp_taken,
  input logic [LC_W-1:0]         lc_cur,
  input logic [PR_N-1:0]         pr_vec,
  input logic [$clog2(GR_N)-1:0] rrb_cur
);
  localparam int unsigned GR_W  = $clog2(GR_N);
  localparam int unsigned ROT_N = GR_N - ROT_BASE;

  // R2
  p0_set_chk: assert property (@(posedge clk) disable iff (!rst_n) pr_vec[0]);

  // R10
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> $past(loop_br & ~(lc_wr | ec_wr | pr_wr)));

  // R9
  collide_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br & (lc_wr | ec_wr | pr_wr)) |=> !resp_vld);

  // R3
  kernel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && $past(lc_cur) != '0) |->
      (resp_taken && lc_cur == LC_W'($past(lc_cur) - 1'b1) && pr_vec[PR_ROT]));

  // R6
  pred_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_taken) |->
      (pr_vec[PR_N-1:PR_ROT+1] == $past(pr_vec[PR_N-2:PR_ROT]) &&
       pr_vec[PR_ROT-1:0] == $past(pr_vec[PR_ROT-1:0])));

  // R7
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_taken) |->
      (rrb_cur == (($past(rrb_cur) == '0) ? GR_W'(ROT_N - 1)
                                          : GR_W'($past(rrb_cur) - 1'b1))));

  // R5
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && !resp_taken) |->
      (pr_vec == $past(pr_vec) && rrb_cur == $past(rrb_cur)));
endmodule

bind modloop_ctl modloop_ctl_chk #(
  .LC_W(LC_W), .EC_W(EC_W), .PR_N(PR_N), .PR_ROT(PR_ROT),
  .GR_N(GR_N), .ROT_BASE(ROT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lc_wr(lc_wr), .ec_wr(ec_wr), .pr_wr(pr_wr),
  .loop_br(loop_br), .resp_vld(resp_vld), .resp_taken(resp_taken),
  .lc_cur(lc_cur), .pr_vec(pr_vec), .rrb_cur(rrb_cur)
);

// File: tb/test_modloop_ctl.sv
`timescale 1ns/1ps
module test_modloop_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lc_wr, ec_wr, pr_wr, loop_br;
  logic [15:0] lc_din;
  logic [5:0]  ec_din;
  logic [63:0] pr_din;
  logic [6:0]  map_log;
  logic        resp_vld, resp_taken;
  logic [15:0] lc_cur;
  logic [5:0]  ec_cur;
  logic [63:0] pr_vec;
  logic [6:0]  rrb_cur, map_phys;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit          taken;
    int          lc;
    int          ec;
    logic [63:0] pr;
    int          rrb;
  } exp_t;
  exp_t exp_q[$];

  // reference state, built from the requirements
  int          m_lc, m_ec, m_rrb;
  logic [63:0] m_pr;

  always #4 clk = ~clk;  // 125 MHz

  modloop_ctl i_modloop_ctl (
    .clk(clk), .rst_n(rst_n), .lc_wr(lc_wr), .lc_din(lc_din),
    .ec_wr(ec_wr), .ec_din(ec_din), .pr_wr(pr_wr), .pr_din(pr_din),
    .loop_br(loop_br), .map_log(map_log), .resp_vld(resp_vld),
    .resp_taken(resp_taken), .lc_cur(lc_cur), .ec_cur(ec_cur),
    .pr_vec(pr_vec), .rrb_cur(rrb_cur), .map_phys(map_phys)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int map_ref(input int idx, input int rrb);
    if (idx < 32) return idx;
    return 32 + ((idx - 32 + rrb) % 96);
  endfunction

  // driver: predicts one branch and pushes the expectation
  task automatic branch();
    exp_t e;
    if (m_lc > 0) begin                      // R3
      m_lc--; e.taken = 1;
      m_pr = {m_pr[62:16], 1'b1, m_pr[15:0]};
    end else if (m_ec > 1) begin             // R4
      m_ec--; e.taken = 1;
      m_pr = {m_pr[62:16], 1'b0, m_pr[15:0]};
    end else begin                           // R5
      if (m_ec > 0) m_ec--;
      e.taken = 0;
    end
    if (e.taken) m_rrb = (m_rrb == 0) ? 95 : m_rrb - 1;  // R7
    e.lc = m_lc; e.ec = m_ec; e.pr = m_pr; e.rrb = m_rrb;
    exp_q.push_back(e);
    @(negedge clk) loop_br = 1'b1;
    @(negedge clk) loop_br = 1'b0;
  endtask

  // monitor: pops and compares each response (R10)
  always @(negedge clk) begin
    if (rst_n && resp_vld) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected resp", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(resp_taken == e.taken, "R3/R4/R5 taken", resp_taken, e.taken);
        chk(lc_cur == e.lc, "R3 lc", lc_cur, e.lc);
        chk(ec_cur == e.ec, "R4/R5 ec", ec_cur, e.ec);
        chk(pr_vec == e.pr, "R6 pred", pr_vec, e.pr);
        chk(rrb_cur == e.rrb, "R7 rrb", rrb_cur, e.rrb);
      end
    end
  end

  task automatic map_chk(input int idx);
    map_log = 7'(idx);
    #1;
    chk(map_phys == map_ref(idx, m_rrb), "R8 map", map_phys, map_ref(idx, m_rrb));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int phys32;
    rst_n = 1'b0; lc_wr = 0; ec_wr = 0; pr_wr = 0; loop_br = 0;
    lc_din = '0; ec_din = '0; pr_din = '0; map_log = '0;
    m_lc = 0; m_ec = 0; m_rrb = 0; m_pr = 64'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(lc_cur == 0, "R1 lc", lc_cur, 0);
    chk(ec_cur == 0, "R1 ec", ec_cur, 0);
    chk(pr_vec == 64'h1, "R1 pred", pr_vec, 64'h1);
    chk(rrb_cur == 0, "R1 rrb", rrb_cur, 0);
    chk(resp_vld == 0, "R1 resp_vld", resp_vld, 0);

    // R9: branch collides with loop count load, must be ignored
    @(negedge clk) begin lc_wr = 1; lc_din = 16'd4; loop_br = 1; end
    @(negedge clk) begin lc_wr = 0; loop_br = 0; end
    m_lc = 4;
    chk(lc_cur == 4, "R9 lc load only", lc_cur, 4);
    chk(resp_vld == 0, "R9 no resp", resp_vld, 0);
    chk(rrb_cur == 0, "R9 rrb kept", rrb_cur, 0);
    chk(pr_vec == 64'h1, "R9 pred kept", pr_vec, 64'h1);

    // R2: epilog count and predicate mask loads, bit 0 written as 0
    @(negedge clk) begin
      ec_wr = 1; ec_din = 6'd4; pr_wr = 1;
      pr_din = (64'h1 << 16) | (64'h1 << 5);
    end
    @(negedge clk) begin ec_wr = 0; pr_wr = 0; end
    m_ec = 4; m_pr = (64'h1 << 16) | (64'h1 << 5) | 64'h1;
    chk(ec_cur == 4, "R2 ec", ec_cur, 4);
    chk(pr_vec == m_pr, "R2 pred p0 forced", pr_vec, m_pr);

    // R8 at base 0
    map_chk(5);
    map_chk(32);
    map_chk(127);

    // 4 kernel branches (R3), 3 drain (R4), exit (R5), exit at ec=0 (R5)
    phys32 = map_ref(32, m_rrb);
    branch();
    map_chk(33);  // R8 wrap at base 95
    chk(map_phys == 7'(phys32), "R8 r32 becomes r33", map_phys, phys32);
    map_chk(127);
    for (int i = 0; i < 8; i++) branch();
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
    chk(pr_vec[19] == 1 && pr_vec[16] == 0, "R4 drain stage pattern",
        pr_vec, m_pr);
    chk(ec_cur == 0, "R5 ec floor", ec_cur, 0);
    map_chk(40);
    map_chk(0);

    // R9: branch colliding with a predicate load
    @(negedge clk) begin pr_wr = 1; pr_din = 64'hF0F0_0000_0001_0000; loop_br = 1; end
    @(negedge clk) begin pr_wr = 0; loop_br = 0; end
    m_pr = 64'hF0F0_0000_0001_0001;
    chk(pr_vec == m_pr, "R9 pred load only", pr_vec, m_pr);
    chk(rrb_cur == 7'(m_rrb), "R9 rrb kept", rrb_cur, m_rrb);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule